// File: doc/BRIEF.md
# Voice PCM Serial Port

This block is the serial sample port of a single-channel linear voice codec. It runs on a fast system clock. It samples an external bit clock, an external frame sync and the serial receive line through two-flop synchronizers, and it finds their edges in the system clock domain.

On transmit, a rising frame sync loads the 14-bit two's-complement sample from the converter side and puts its most significant bit out immediately. Each later rising bit-clock edge presents the next bit. The output is modelled as an open-drain pin: an enable plus a data bit. The pin is pulled low only when the enable is set and the bit is 0, and the enable is set only during the 14-bit slot. On receive, the bits are taken on falling bit-clock edges, most significant bit first. After the 14th bit the whole word is presented in parallel with a one-cycle strobe.

A stalled bit clock or frame sync (no edge for a programmable number of system clocks) puts both directions into power saving. The next frame clears it. A low power-on input forces the power-down condition.

The controller has five states:
- ST_DOWN: the power-on input is low.
- ST_IDLE: awake, waiting for a frame.
- ST_SLOT: the 14-bit transmit slot.
- ST_TAIL: the slot has ended and the port waits for the next sync.
- ST_SAVE: power saving.

Its transitions, in priority order:
- Any state goes to ST_DOWN while power-on is low.
- ST_DOWN goes to ST_IDLE when power-on is high.
- ST_IDLE, ST_SLOT, ST_TAIL and ST_SAVE go to ST_SLOT on a sync rise while the bit clock is not stalled (launch). This includes a restart inside ST_SLOT.
- ST_IDLE, ST_SLOT and ST_TAIL go to ST_SAVE on a stall.
- ST_SLOT goes to ST_TAIL on the bit-clock rise that ends the 14th bit.

Top module: `vpcm_port`

## Requirements
- R1: After reset, tx_en_o is 0, tx_bit_o is 1, rx_valid_o is 0 and psave_o is 0.
- R2: On a frame sync rise (power on, bit clock running), tx_en_o becomes 1 and tx_bit_o carries bit 13 (the sign bit) of tx_sample_i before the next bit-clock edge.
- R3: During bit period k (k = 0 to 13, counted in bit-clock rises from the sync rise), tx_bit_o equals bit 13-k of the loaded sample. tx_bit_o changes only after a bit-clock rise.
- R4: From the 14th bit-clock rise after the sync rise until the next sync rise, tx_en_o is 0. tx_bit_o reads 1 whenever tx_en_o is 0.
- R5: ser_rx_i is taken on falling bit-clock edges. The first fall after a sync rise gives bit 13. After the 14th fall, rx_sample_o holds the word and rx_valid_o is 1 for exactly one system clock.
- R6: Further bit-clock falls in the same frame are ignored: there is no second strobe, and rx_sample_o is unchanged.
- R7: With no bit-clock edge for clk_gap_lim_i system clocks, psave_o becomes 1, tx_en_o is 0, and a partly received word is discarded without a strobe.
- R8: With no frame sync edge for sync_gap_lim_i system clocks, psave_o becomes 1 and tx_en_o is 0.
- R9: In power saving, the next sync rise with the bit clock running clears psave_o, and that frame is sent and received normally.
- R10: While pwr_on_i is 0, tx_en_o, rx_valid_o and psave_o are 0 and any frame is abandoned. After pwr_on_i returns to 1, the next sync starts a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | 1 = operate, 0 = power down |
| bit_clk_i | input | 1 | External serial bit clock (asynchronous) |
| frame_sync_i | input | 1 | External frame sync (asynchronous) |
| ser_rx_i | input | 1 | Serial receive data |
| clk_gap_lim_i | input | CW | System clocks without a bit-clock edge that mean a stall |
| sync_gap_lim_i | input | CW | System clocks without a sync edge that mean a stall |
| tx_sample_i | input | W | Sample to send, two's complement |
| tx_en_o | output | 1 | Open-drain enable; the pin is driven only while 1 |
| tx_bit_o | output | 1 | Serial data; the pin is pulled low when tx_en_o is 1 and this is 0 |
| rx_sample_o | output | W | Last complete received word, two's complement |
| rx_valid_o | output | 1 | One-cycle strobe when rx_sample_o updates |
| psave_o | output | 1 | Power-saving condition |

## Verification
The assertions assume that the external bit clock is slow against the system clock, that the frame sync and serial data change only together with a rising bit clock, and that the gap limits are non-zero and constant. They also assume that the sync stays high and low for at least one bit period. The stimulus drives every external input at the falling system-clock edge. It uses 8 system clocks per bit-clock half period and 16 bit periods per frame. The sync is raised together with the bit clock and held high for one full bit period, and the limits are held at 40 and 300, well above the normal edge spacing.

// File: rtl/vpcm_pkg.sv
package vpcm_pkg;
    localparam int unsigned SAMPLE_W = 14;

    typedef enum logic [2:0] {
        ST_DOWN,
        ST_IDLE,
        ST_SLOT,
        ST_TAIL,
        ST_SAVE
    } port_state_e;
endpackage

// File: rtl/vpcm_edge_det.sv
module vpcm_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic rise_o,
    output logic fall_o
);
    // stage 0 and 1 synchronize, stage 2 holds the previous level
    logic [2:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[1:0], raw_i};
    end

    assign rise_o = stg_q[1] & ~stg_q[2];
    assign fall_o = ~stg_q[1] & stg_q[2];
endmodule

// File: rtl/vpcm_gap_watch.sv
module vpcm_gap_watch #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          edge_i,
    input  logic [CW-1:0] lim_i,
    output logic          stalled_o
);
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (clr_i || edge_i)  gap_q <= '0;
        else if (gap_q < lim_i)    gap_q <= gap_q + 1'b1;
    end

    // an edge seen this cycle masks the flag so a waking frame is accepted
    assign stalled_o = (gap_q >= lim_i) && !edge_i;

    // R9: any edge ends the stall on the following cycle
    a_r9_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !clr_i && lim_i != '0 && $stable(lim_i)) |=> !stalled_o);
endmodule

// File: rtl/vpcm_port.sv
module vpcm_port
    import vpcm_pkg::*;
#(
    parameter int unsigned W  = SAMPLE_W,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_on_i,
    input  logic          bit_clk_i,
    input  logic          frame_sync_i,
    input  logic          ser_rx_i,
    input  logic [CW-1:0] clk_gap_lim_i,
    input  logic [CW-1:0] sync_gap_lim_i,
    input  logic [W-1:0]  tx_sample_i,
    output logic          tx_en_o,
    output logic          tx_bit_o,
    output logic [W-1:0]  rx_sample_o,
    output logic          rx_valid_o,
    output logic          psave_o
);
    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    port_state_e state_q, state_d;

    logic clk_rise, clk_fall, sy_rise, sy_fall;
    logic clk_stall, sy_stall, any_stall, launch;
    logic [1:0] din_q;

    logic [W-1:0]     tx_sh_q;
    logic [CNT_W-1:0] tx_cnt_q;
    logic [W-2:0]     rx_sh_q;
    logic [CNT_W-1:0] rx_cnt_q;
    logic             rx_act_q;
    logic [W-1:0]     rx_word_q;
    logic             rx_valid_q;

    // ---------------- input conditioning ----------------
    vpcm_edge_det u_clk_edge (
        .clk(clk), .rst_n(rst_n), .raw_i(bit_clk_i),
        .rise_o(clk_rise), .fall_o(clk_fall)
    );
    vpcm_edge_det u_sync_edge (
        .clk(clk), .rst_n(rst_n), .raw_i(frame_sync_i),
        .rise_o(sy_rise), .fall_o(sy_fall)
    );

    // data takes the same two-flop delay as the clock edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= {din_q[0], ser_rx_i};
    end

    vpcm_gap_watch #(.CW(CW)) u_clk_gap (
        .clk(clk), .rst_n(rst_n), .clr_i(!pwr_on_i),
        .edge_i(clk_rise | clk_fall), .lim_i(clk_gap_lim_i),
        .stalled_o(clk_stall)
    );
    vpcm_gap_watch #(.CW(CW)) u_sync_gap (
        .clk(clk), .rst_n(rst_n), .clr_i(!pwr_on_i),
        .edge_i(sy_rise | sy_fall), .lim_i(sync_gap_lim_i),
        .stalled_o(sy_stall)
    );

    assign any_stall = clk_stall | sy_stall;
    assign launch    = pwr_on_i && sy_rise && !clk_stall && (state_q != ST_DOWN);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN: if (pwr_on_i) state_d = ST_IDLE;
            ST_IDLE,
            ST_TAIL: begin
                if (launch)         state_d = ST_SLOT;
                else if (any_stall) state_d = ST_SAVE;
            end
            ST_SLOT: begin
                if (launch)                               state_d = ST_SLOT;
                else if (any_stall)                       state_d = ST_SAVE;
                else if (clk_rise && tx_cnt_q == LAST_IDX) state_d = ST_TAIL;
            end
            ST_SAVE: if (launch) state_d = ST_SLOT;
            default: state_d = ST_IDLE;
        endcase
        if (!pwr_on_i) state_d = ST_DOWN;
    end

    // ---------------- transmit shifter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q  <= '0;
            tx_cnt_q <= '0;
        end else if (launch) begin
            tx_sh_q  <= tx_sample_i;
            tx_cnt_q <= '0;
        end else if (state_q == ST_SLOT && clk_rise) begin
            tx_sh_q  <= {tx_sh_q[W-2:0], 1'b0};
            tx_cnt_q <= tx_cnt_q + 1'b1;
        end
    end

    // ---------------- receive shifter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q    <= '0;
            rx_cnt_q   <= '0;
            rx_act_q   <= 1'b0;
            rx_word_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (launch) begin
                rx_act_q <= 1'b1;
                rx_cnt_q <= '0;
            end else if (!pwr_on_i || any_stall) begin
                rx_act_q <= 1'b0;
            end else if (rx_act_q && clk_fall) begin
                rx_sh_q  <= {rx_sh_q[W-3:0], din_q[1]};
                rx_cnt_q <= rx_cnt_q + 1'b1;
                if (rx_cnt_q == LAST_IDX) begin
                    rx_word_q  <= {rx_sh_q, din_q[1]};
                    rx_valid_q <= 1'b1;
                    rx_act_q   <= 1'b0;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        tx_en_o     = (state_q == ST_SLOT);
        tx_bit_o    = (state_q == ST_SLOT) ? tx_sh_q[W-1] : 1'b1;
        psave_o     = (state_q == ST_SAVE);
        rx_sample_o = rx_word_q;
        rx_valid_o  = rx_valid_q;
    end

    // ---------------- assertions ----------------
    a_r2_launch_drives: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> tx_en_o);

    a_r3_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o && !clk_rise && !launch && pwr_on_i && !any_stall)
            |=> $stable(tx_bit_o));

    a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on_i |=> (!tx_en_o && !rx_valid_o && !psave_o));
endmodule

// File: tb/vpcm_port_tb.sv
module vpcm_port_tb;
    localparam int W  = 14;
    localparam int CW = 16;
    localparam int HALF = 8;
    localparam int NVEC = 6;
    // {tx word, rx word}
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {14'h1FFF, 14'h2000},
        {14'h2000, 14'h1FFF},
        {14'h0000, 14'h3FFF},
        {14'h3FFF, 14'h0000},
        {14'h0001, 14'h2AB5},
        {14'h154A, 14'h0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 1'b1;
    logic bclk = 1'b0;
    logic fsy = 1'b0;
    logic din = 1'b0;
    logic [CW-1:0] clk_lim = 16'd40;
    logic [CW-1:0] sy_lim  = 16'd300;
    logic [W-1:0] tx_sample = '0;
    logic tx_en, tx_bit, rx_valid, psave;
    logic [W-1:0] rx_sample;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [W-1:0] last_rx = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vpcm_port #(.W(W), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on),
        .bit_clk_i(bclk), .frame_sync_i(fsy), .ser_rx_i(din),
        .clk_gap_lim_i(clk_lim), .sync_gap_lim_i(sy_lim),
        .tx_sample_i(tx_sample), .tx_en_o(tx_en), .tx_bit_o(tx_bit),
        .rx_sample_o(rx_sample), .rx_valid_o(rx_valid), .psave_o(psave)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount  <= vcount + 1;
            last_rx <= rx_sample;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [W-1:0] tx_w, input logic [W-1:0] rx_w,
                             input int nper, input bit want_rx);
        int v0;
        v0 = vcount;
        tx_sample = tx_w;
        for (int i = 0; i < nper; i++) begin
            bclk = 1'b1;
            fsy  = (i == 0);
            din  = (i < W) ? rx_w[W-1-i] : i[0];
            repeat (HALF) @(negedge clk);
            if (i == 0)
                chk(tx_en && tx_bit == tx_w[W-1], "R2 sign bit at sync",
                    {tx_en, tx_bit}, {1'b1, tx_w[W-1]});
            else if (i < W)
                chk(tx_en && tx_bit == tx_w[W-1-i], "R3 tx bit",
                    {tx_en, tx_bit}, {1'b1, tx_w[W-1-i]});
            else
                chk(!tx_en && tx_bit, "R4 released after slot",
                    {tx_en, tx_bit}, 2'b01);
            bclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        if (want_rx) begin
            chk(vcount == v0 + 1 && last_rx == rx_w, "R5 rx word",
                last_rx, rx_w);
            if (nper > W)
                chk(vcount == v0 + 1 && rx_sample == rx_w, "R6 extra bits ignored",
                    vcount - v0, 1);
        end
    endtask

    task automatic idle_periods(input int n);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1; fsy = 1'b0; din = i[0];
            repeat (HALF) @(negedge clk);
            bclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(!tx_en && tx_bit && !rx_valid && !psave, "R1 reset state",
            {tx_en, tx_bit, rx_valid, psave}, 4'b0100);

        // main vectors, back-to-back frames of 16 bit periods
        for (int k = 0; k < NVEC; k++)
            run_frame(VEC[k][2*W-1:W], VEC[k][W-1:0], 16, 1'b1);

        // R7: bit clock stops mid-frame
        v0 = vcount;
        run_frame(14'h1234, 14'h0F0F, 5, 1'b0);
        repeat (80) @(negedge clk);
        chk(psave && !tx_en, "R7 clock stall power save", {psave, tx_en}, 2'b10);
        chk(vcount == v0, "R7 partial word dropped", vcount - v0, 0);

        // R9: next frame wakes the port
        run_frame(14'h2A55, 14'h1555, 16, 1'b1);
        chk(!psave, "R9 wake on frame", psave, 0);

        // R8: sync stays low while the bit clock runs
        idle_periods(30);
        chk(psave && !tx_en, "R8 sync stall power save", {psave, tx_en}, 2'b10);
        run_frame(14'h3001, 14'h0FFE, 16, 1'b1);
        chk(!psave, "R9 wake after sync stall", psave, 0);

        // R10: power down during a frame
        v0 = vcount;
        run_frame(14'h3FFF, 14'h3FFF, 6, 1'b0);
        pwr_on = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_en && tx_bit && !psave, "R10 powered down outputs",
            {tx_en, tx_bit, psave}, 3'b010);
        idle_periods(10);
        chk(vcount == v0 && !psave, "R10 no strobe while down", vcount - v0, 0);
        pwr_on = 1'b1;
        run_frame(14'h0A0A, 14'h3535, 16, 1'b1);
        chk(!psave, "R10 normal after power up", psave, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule